// File: doc/BRIEF.md
# NAND Hamming ECC Syndrome Decoder

This block sits beside the hardware parity engine of a NAND flash controller and handles one 512-byte sector at a time. On the write side, it packs the engine's 32-bit column/row parity word into a 24-bit code. It inverts that code so that an erased page, read back as all ones, carries a consistent code. It then presents the code as three byte lanes for the spare area.

On the read side, software or a sequencer offers a compare request. The request holds the code just computed over the data read back and the code fetched from the spare area. One cycle after the request is accepted, the block reports one of four results:

- the sector is clean;
- one data bit is wrong, and the block gives its byte offset and bit position;
- only the stored code took a single-bit hit;
- the damage cannot be repaired.

A streaming path can then replay the sector bytes. It flips the faulty bit in flight, with a fixed one-cycle latency.

Top module: `ecc_syndrome_top`

## Requirements
- R1: The 24-bit stored code equals the bitwise inverse of {raw_parity[27:16], raw_parity[11:0]}. Raw bits 15:12 and 31:28 have no effect on it.
- R2: The stored code appears least significant byte first: code_b0 carries code bits 7:0, code_b1 carries bits 15:8 and code_b2 carries bits 23:16.
- R3: When calc_code equals read_code (difference d = calc_code ^ read_code is zero), the status is 0 (clean).
- R4: When d[23:12] ^ d[11:0] equals 12'hFFF and the offset d[23:15] is below SECTOR_BYTES, the status is 1 (corrected data). res_offset then equals d[23:15] and res_bit equals d[14:12].
- R5: A difference that passes the complement test of R4 but whose offset d[23:15] is SECTOR_BYTES or more gives status 3 (uncorrectable).
- R6: A nonzero d that fails the complement test and has exactly one bit set gives status 2 (error in the code only).
- R7: Any other nonzero d gives status 3.
- R8: A request is accepted when req_valid and req_ready are both high. res_valid is high for exactly the one cycle after each acceptance. req_ready is high only while no sector byte is being offered and the streaming byte counter sits at the start of a sector.
- R9: When the latest status is 1, each streamed byte leaves on m_data one cycle after it entered. The byte whose index within the sector equals res_offset has bit res_bit inverted. The counter wraps after SECTOR_BYTES bytes.
- R10: When the latest status is not 1, every streamed byte passes through unchanged with one cycle of latency.
- R11: A synchronous active-low reset clears res_valid, m_valid, the status (to 0) and the streaming byte counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| raw_parity | input | 32 | Parity word from the ECC engine for one sector |
| code_b0 | output | 8 | Stored code, bits 7:0 |
| code_b1 | output | 8 | Stored code, bits 15:8 |
| code_b2 | output | 8 | Stored code, bits 23:16 |
| req_valid | input | 1 | Compare request offered |
| req_ready | output | 1 | Compare request can be taken |
| calc_code | input | 24 | Code computed over the data read back |
| read_code | input | 24 | Code fetched from the spare area |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| res_status | output | 2 | 0 clean, 1 corrected data, 2 code-only error, 3 uncorrectable |
| res_offset | output | 9 | Byte offset of the faulty data bit |
| res_bit | output | 3 | Bit position of the faulty data bit |
| s_valid | input | 1 | Sector byte offered for replay |
| s_data | input | 8 | Sector byte in |
| m_valid | output | 1 | Replayed byte valid |
| m_data | output | 8 | Replayed byte, repaired where needed |

## Verification
The properties rely on these conditions on the inputs:
- all inputs are known, with no X values, whenever their valid flag is high;
- a compare request is only counted as taken in a cycle where req_ready is high;
- sector bytes arrive in order, starting from a sector boundary.

The stimulus drives every input on the falling edge from fixed, fully defined values. It issues compare requests only between whole sectors, and it opens every replay at a sector start, either after a full sector or after reset. A deliberate gap inside a replay is held with s_valid low and no request pending.

// File: rtl/ecc_syn_pkg.sv
// Shared constants and the result encoding of the ECC syndrome decoder.
// Assumes the fixed 24-bit code format: two 12-bit parity halves per sector.
package ecc_syn_pkg;
    localparam int RAW_W  = 32;
    localparam int CODE_W = 24;
    localparam int HALF_W = 12;
    localparam int BITS_W = 3;
    localparam int OFF_W  = HALF_W - BITS_W;
    localparam int LANES  = CODE_W / 8;

    typedef enum logic [1:0] {
        ST_CLEAN     = 2'd0,
        ST_FIXED     = 2'd1,
        ST_CODE_ONLY = 2'd2,
        ST_UNCORR    = 2'd3
    } ecc_status_e;
endpackage

// File: rtl/ecc_code_pack.sv
// Packs the engine's raw parity word into the stored code: the low half
// stays put, the upper half drops four unused bits, and the result is
// inverted so that erased flash decodes as a matching code.
// Assumes raw bits 15:12 and 31:28 carry nothing of value.
module ecc_code_pack
    import ecc_syn_pkg::*;
(
    input  logic [RAW_W-1:0]  raw,
    output logic [CODE_W-1:0] code
);
    localparam logic [RAW_W-1:0] LOW_MASK  = RAW_W'((1 << HALF_W) - 1);
    localparam logic [RAW_W-1:0] HIGH_MASK = LOW_MASK << HALF_W;

    logic [RAW_W-1:0] squeezed;

    // Squeeze out the gap between the halves, then invert.
    always_comb begin
        squeezed = (raw & LOW_MASK) | ((raw >> 4) & HIGH_MASK);
        code     = ~squeezed[CODE_W-1:0];
    end
endmodule

// File: rtl/ecc_diff_classify.sv
// Classifies the difference between a computed and a stored code and
// locates a single faulty data bit.
// Assumes SECTOR_BYTES does not exceed the 512 bytes the offset field spans.
module ecc_diff_classify
    import ecc_syn_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic [CODE_W-1:0] calc,
    input  logic [CODE_W-1:0] stored,
    output ecc_status_e       status,
    output logic [OFF_W-1:0]  offset,
    output logic [BITS_W-1:0] bitpos
);
    localparam logic [OFF_W:0] LIMIT = (OFF_W+1)'(SECTOR_BYTES);

    logic [CODE_W-1:0] diff;
    logic [HALF_W-1:0] lo_half;
    logic [HALF_W-1:0] hi_half;
    logic              complement;
    logic              single_bit;
    logic              in_range;

    // Split the difference and derive the tests it is judged by.
    always_comb begin
        diff       = calc ^ stored;
        lo_half    = diff[HALF_W-1:0];
        hi_half    = diff[CODE_W-1:HALF_W];
        complement = ((hi_half ^ lo_half) == {HALF_W{1'b1}});
        single_bit = ((diff & (diff - CODE_W'(1))) == '0);
        offset     = diff[CODE_W-1:HALF_W+BITS_W];
        bitpos     = diff[HALF_W+BITS_W-1:HALF_W];
        in_range   = ({1'b0, offset} < LIMIT);
    end

    // Choose the outcome, complement test first.
    always_comb begin
        if (diff == '0)
            status = ST_CLEAN;
        else if (complement)
            status = in_range ? ST_FIXED : ST_UNCORR;
        else if (single_bit)
            status = ST_CODE_ONLY;
        else
            status = ST_UNCORR;
    end
endmodule

// File: rtl/ecc_stream_fix.sv
// Replays sector bytes with one cycle of latency and inverts the chosen
// bit of the byte whose index matches the repair offset.
// Assumes bytes arrive in order from a sector boundary; the repair
// inputs hold steady for the whole sector.
module ecc_stream_fix
    import ecc_syn_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fix_en,
    input  logic [OFF_W-1:0]  fix_off,
    input  logic [BITS_W-1:0] fix_bit,
    input  logic              s_valid,
    input  logic [7:0]        s_data,
    output logic              m_valid,
    output logic [7:0]        m_data,
    output logic              at_start
);
    localparam logic [OFF_W-1:0] LAST = OFF_W'(SECTOR_BYTES - 1);

    logic [OFF_W-1:0] byte_cnt;
    logic             hit;
    logic [7:0]       mask;

    // Flag the byte that carries the faulty bit.
    always_comb hit = fix_en && (byte_cnt == fix_off);

    // One mask bit per lane, lit only for the reported position.
    for (genvar g = 0; g < 8; g++) begin : g_mask
        always_comb mask[g] = hit && (fix_bit == BITS_W'(g));
    end

    // Count bytes within the sector, wrapping at its end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            byte_cnt <= '0;
        else if (s_valid)
            byte_cnt <= (byte_cnt == LAST) ? '0 : byte_cnt + OFF_W'(1);
    end

    // Register each byte out, repaired where the mask says so.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 1'b0;
            m_data  <= '0;
        end else begin
            m_valid <= s_valid;
            if (s_valid)
                m_data <= s_data ^ mask;
        end
    end

    // Report when the next byte starts a sector.
    always_comb at_start = (byte_cnt == '0);
endmodule

// File: rtl/ecc_syndrome_top.sv
// Top of the ECC syndrome decoder: stored-code packing, the compare
// request with its registered result, and the repairing byte stream.
// Assumes requests are issued only between sectors.
module ecc_syndrome_top
    import ecc_syn_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] raw_parity,
    output logic [7:0]  code_b0,
    output logic [7:0]  code_b1,
    output logic [7:0]  code_b2,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [23:0] calc_code,
    input  logic [23:0] read_code,
    output logic        res_valid,
    output logic [1:0]  res_status,
    output logic [8:0]  res_offset,
    output logic [2:0]  res_bit,
    input  logic        s_valid,
    input  logic [7:0]  s_data,
    output logic        m_valid,
    output logic [7:0]  m_data
);
    logic [CODE_W-1:0]           packed_code;
    logic [LANES-1:0][7:0]       lanes;
    ecc_status_e                 cls_status;
    logic [OFF_W-1:0]            cls_offset;
    logic [BITS_W-1:0]           cls_bit;
    ecc_status_e                 status_q;
    logic [OFF_W-1:0]            offset_q;
    logic [BITS_W-1:0]           bit_q;
    logic                        stream_start;
    logic                        accept;

    ecc_code_pack u_pack (
        .raw  (raw_parity),
        .code (packed_code)
    );

    // Split the code into byte lanes, least significant first.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb lanes[g] = packed_code[8*g +: 8];
    end

    always_comb begin
        code_b0 = lanes[0];
        code_b1 = lanes[1];
        code_b2 = lanes[2];
    end

    ecc_diff_classify #(.SECTOR_BYTES(SECTOR_BYTES)) u_cls (
        .calc   (calc_code),
        .stored (read_code),
        .status (cls_status),
        .offset (cls_offset),
        .bitpos (cls_bit)
    );

    // Take requests only at a sector boundary with no byte on offer.
    always_comb begin
        req_ready = stream_start && !s_valid;
        accept    = req_valid && req_ready;
    end

    // Pulse the result flag in the cycle after an acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            res_valid <= 1'b0;
        else
            res_valid <= accept;
    end

    // Capture the classification of each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= ST_CLEAN;
            offset_q <= '0;
            bit_q    <= '0;
        end else if (accept) begin
            status_q <= cls_status;
            offset_q <= cls_offset;
            bit_q    <= cls_bit;
        end
    end

    always_comb begin
        res_status = status_q;
        res_offset = offset_q;
        res_bit    = bit_q;
    end

    ecc_stream_fix #(.SECTOR_BYTES(SECTOR_BYTES)) u_stream (
        .clk      (clk),
        .rst_n    (rst_n),
        .fix_en   (status_q == ST_FIXED),
        .fix_off  (offset_q),
        .fix_bit  (bit_q),
        .s_valid  (s_valid),
        .s_data   (s_data),
        .m_valid  (m_valid),
        .m_data   (m_data),
        .at_start (stream_start)
    );
endmodule

// File: rtl/ecc_syndrome_chk.sv
// Checker for the ECC syndrome decoder, attached to every instance of the
// top module. Observes ports only.
module ecc_syndrome_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [23:0] calc_code,
    input logic [23:0] read_code,
    input logic        res_valid,
    input logic [1:0]  res_status,
    input logic        s_valid,
    input logic [7:0]  s_data,
    input logic        m_valid,
    input logic [7:0]  m_data
);
    // R8
    accept_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> res_valid);

    // R8
    pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (!res_valid || $past(req_valid && req_ready)));

    // R3
    clean_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && calc_code == read_code) |=> res_status == 2'd0);

    // R6
    code_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && $countones(calc_code ^ read_code) == 1)
        |=> res_status == 2'd2);

    // R9
    stream_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid |=> m_valid);

    // R9
    one_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid |=> $countones(m_data ^ $past(s_data)) <= 1);

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && !m_valid && res_status == 2'd0));
endmodule

bind ecc_syndrome_top ecc_syndrome_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .calc_code  (calc_code),
    .read_code  (read_code),
    .res_valid  (res_valid),
    .res_status (res_status),
    .s_valid    (s_valid),
    .s_data     (s_data),
    .m_valid    (m_valid),
    .m_data     (m_data)
);

// File: tb/sim_ecc_syndrome_top.sv
// Sweeping bench for the ECC syndrome decoder with a 384-byte sector, so
// that offsets at and past the sector end are reachable.
module sim_ecc_syndrome_top;
    localparam int SECTOR = 384;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] raw_parity = '0;
    logic [7:0]  code_b0, code_b1, code_b2;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] calc_code = '0;
    logic [23:0] read_code = '0;
    logic        res_valid;
    logic [1:0]  res_status;
    logic [8:0]  res_offset;
    logic [2:0]  res_bit;
    logic        s_valid = 1'b0;
    logic [7:0]  s_data = '0;
    logic        m_valid;
    logic [7:0]  m_data;

    int n_chk = 0;
    int n_fail = 0;

    ecc_syndrome_top #(.SECTOR_BYTES(SECTOR)) u0 (.*);

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Issue one compare request; called just after a falling edge.
    task automatic do_req(input logic [23:0] c, input logic [23:0] r,
                          input logic [1:0] est, input logic [8:0] eoff,
                          input logic [2:0] ebit, input bit loc, input string tag);
        calc_code = c;
        read_code = r;
        req_valid = 1'b1;
        check(req_ready == 1'b1, "R8 ready", 32'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        check(res_valid == 1'b1, "R8 pulse", 32'(res_valid), 1);
        check(res_status == est, tag, 32'(res_status), 32'(est));
        if (loc) begin
            check(res_offset == eoff, tag, 32'(res_offset), 32'(eoff));
            check(res_bit == ebit, tag, 32'(res_bit), 32'(ebit));
        end
        @(negedge clk);
        check(res_valid == 1'b0, "R8 pulse end", 32'(res_valid), 0);
    endtask

    // Replay one sector; flip tells whether a repair is expected.
    task automatic run_stream(input bit flip, input int off, input int bpos,
                              input int seed, input string tag);
        for (int i = 0; i < SECTOR; i++) begin
            logic [7:0] d;
            logic [7:0] e;
            if (i == 200) begin
                s_valid = 1'b0;
                @(negedge clk);
                check(req_ready == 1'b0, "R8 mid-sector", 32'(req_ready), 0);
                check(m_valid == 1'b0, "R9 gap", 32'(m_valid), 0);
            end
            d = 8'(i * 7 + seed);
            e = (flip && i == off) ? (d ^ 8'(1 << bpos)) : d;
            s_valid = 1'b1;
            s_data  = d;
            @(negedge clk);
            check(m_valid == 1'b1 && m_data == e, tag, 32'(m_data), 32'(e));
        end
        s_valid = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R9 wrap", 32'(req_ready), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [23:0] exp_code;
        logic [23:0] base;
        logic [11:0] hi;

        repeat (3) @(negedge clk);
        // R11 reset state
        check(res_valid == 1'b0, "R11", 32'(res_valid), 0);
        check(m_valid == 1'b0, "R11", 32'(m_valid), 0);
        check(res_status == 2'd0, "R11", 32'(res_status), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 and R2: walking ones and hashed words through the packer
        for (int k = 0; k < 232; k++) begin
            raw_parity = (k < 32) ? (32'd1 << k) : 32'(k * 32'h9E3779B1);
            #1;
            exp_code = ~24'((raw_parity & 32'hFFF) | ((raw_parity >> 4) & 32'hFFF000));
            check({code_b2, code_b1, code_b0} == exp_code, "R1",
                  32'({code_b2, code_b1, code_b0}), 32'(exp_code));
            check(code_b0 == exp_code[7:0] && code_b2 == exp_code[23:16], "R2",
                  32'(code_b0), 32'(exp_code[7:0]));
        end
        // R1: an all-zero parity word (erased sector) gives an all-ones code
        raw_parity = '0;
        #1;
        check({code_b2, code_b1, code_b0} == 24'hFFFFFF, "R1 erased",
              32'({code_b2, code_b1, code_b0}), 32'hFFFFFF);
        @(negedge clk);

        // R3: equal codes
        for (int k = 0; k < 8; k++) begin
            base = 24'(k * 40503 + 7);
            do_req(base, base, 2'd0, 9'd0, 3'd0, 1'b0, "R3");
        end

        // R4 and R5: every offset and bit with a complementary difference
        for (int off = 0; off < 512; off++) begin
            for (int b = 0; b < 8; b++) begin
                base = 24'(off * 977 + b * 131);
                hi = {9'(off), 3'(b)};
                if (off < SECTOR)
                    do_req(base, base ^ {hi, ~hi}, 2'd1, 9'(off), 3'(b), 1'b1, "R4");
                else
                    do_req(base, base ^ {hi, ~hi}, 2'd3, 9'd0, 3'd0, 1'b0, "R5");
            end
        end

        // R6: a single bit differs
        for (int p = 0; p < 24; p++)
            do_req(24'h5A5A5A, 24'h5A5A5A ^ (24'd1 << p), 2'd2, 9'd0, 3'd0, 1'b0, "R6");

        // R7: two bits differ
        for (int p = 0; p < 24; p++)
            for (int q = p + 1; q < 24; q++)
                do_req(24'h123456, 24'h123456 ^ (24'd1 << p) ^ (24'd1 << q),
                       2'd3, 9'd0, 3'd0, 1'b0, "R7");

        // R9: repairs in the middle and at both ends of the sector
        hi = {9'd100, 3'd5};
        do_req(24'h0, {hi, ~hi}, 2'd1, 9'd100, 3'd5, 1'b1, "R4");
        run_stream(1'b1, 100, 5, 3, "R9 mid");
        hi = {9'd0, 3'd0};
        do_req(24'h0, {hi, ~hi}, 2'd1, 9'd0, 3'd0, 1'b1, "R4");
        run_stream(1'b1, 0, 0, 11, "R9 first");
        hi = {9'(SECTOR - 1), 3'd7};
        do_req(24'h0, {hi, ~hi}, 2'd1, 9'(SECTOR - 1), 3'd7, 1'b1, "R4");
        run_stream(1'b1, SECTOR - 1, 7, 29, "R9 last");

        // R10: code-only and out-of-range results leave the bytes alone
        do_req(24'h0, 24'h000400, 2'd2, 9'd0, 3'd0, 1'b0, "R6");
        run_stream(1'b0, 0, 0, 5, "R10 code-only");
        hi = {9'd400, 3'd2};
        do_req(24'h0, {hi, ~hi}, 2'd3, 9'd0, 3'd0, 1'b0, "R5");
        run_stream(1'b0, 0, 0, 17, "R10 uncorrectable");

        // R11: reset part-way through a sector
        hi = {9'd3, 3'd1};
        do_req(24'h0, {hi, ~hi}, 2'd1, 9'd3, 3'd1, 1'b1, "R4");
        for (int i = 0; i < 10; i++) begin
            s_valid = 1'b1;
            s_data  = 8'(i);
            @(negedge clk);
        end
        s_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(res_valid == 1'b0, "R11 mid", 32'(res_valid), 0);
        check(m_valid == 1'b0, "R11 mid", 32'(m_valid), 0);
        check(res_status == 2'd0, "R11 mid", 32'(res_status), 0);
        check(req_ready == 1'b1, "R11 counter", 32'(req_ready), 1);
        run_stream(1'b0, 0, 0, 41, "R11 after reset");

        summary();
    end
endmodule